// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Pair

This block performs integer multiplication and division over several clock cycles and keeps its results in a dedicated pair of result registers, an upper word `hi` and a lower word `lo`. A caller presents an operation code and two operands together with a one-cycle `start` pulse. Multiplies and divides then run a bit-serial sequence: shift-add for the product, restoring subtraction for the quotient. A `busy` flag is raised while the sequence runs. The two result registers can also be loaded directly from the first operand, and both are always visible at the outputs for move-from reads.

A multiply leaves the full double-width product split across the pair. A divide leaves the quotient in `lo` and the remainder in `hi`. No condition ever signals an error. A zero divisor yields a fixed, defined answer in the usual number of cycles. The caller must hold off reads of the pair, and new requests, while `busy` is high. Requests made during that time are dropped.

Top module: `muldiv_unit`

## Requirements
- R1: Op code 1 (unsigned multiply) treats both operands as unsigned and writes the 64-bit product with bits 31:0 to `lo` and bits 63:32 to `hi`.
- R2: Op code 0 (signed multiply) treats both operands as two's-complement and writes the signed 64-bit product, split as in R1.
- R3: Op code 3 (unsigned divide) writes the unsigned quotient `opa / opb` to `lo` and the remainder to `hi`.
- R4: Op code 2 (signed divide) truncates the quotient toward zero and gives the remainder the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R5: A divide (op code 2 or 3) with `opb` = 0 completes in the normal time with `lo` = 0xFFFFFFFF and `hi` = `opa`.
- R6: Once a multiply or divide is accepted at a clock edge, `busy` is high from that edge for exactly 33 cycles. `hi` and `lo` take the new result at the edge where `busy` falls.
- R7: Op code 4 loads `hi` from `opa`, and op code 5 loads `lo` from `opa`. Each load happens at the accepting edge, leaves the other register unchanged and does not raise `busy`.
- R8: Any `start` seen while `busy` is high is ignored. `hi` and `lo` keep their values until the running operation writes its own result.
- R9: After reset `busy` is low and `hi` and `lo` are zero.
- R10: Op codes 6 and 7 are no-operations. A `start` with them leaves `busy` low and `hi`/`lo` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled when idle |
| op | input | 3 | Operation code (0 smul, 1 umul, 2 sdiv, 3 udiv, 4 load hi, 5 load lo) |
| opa | input | 32 | Multiplicand / dividend / value to load |
| opb | input | 32 | Multiplier / divisor |
| busy | output | 1 | High while a multiply or divide is running |
| hi | output | 32 | Upper result register |
| lo | output | 32 | Lower result register |

## Verification
The bench builds the unit at its default 32-bit width. At that width the corner operands are reachable directly: the most negative value divided by minus one, an all-ones times all-ones product that fills all 64 bits, and zero divisors of both signs. It also exposes the 33-cycle occupancy, which a reference model tracks cycle by cycle so that every dropped request made during that window shows up against `busy`, `hi` and `lo`.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_SMUL = 3'd0,
    OP_UMUL = 3'd1,
    OP_SDIV = 3'd2,
    OP_UDIV = 3'd3,
    OP_LDHI = 3'd4,
    OP_LDLO = 3'd5
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic step,
  output logic fix
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  md_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_RUN;
      ST_RUN:  if (cnt_q == LAST_STEP) state_d = ST_FIX;
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign step   = (state_q == ST_RUN);
  assign fix    = (state_q == ST_FIX);
  assign busy   = (state_q != ST_IDLE);
  assign cnt_en = launch | step;
  assign cnt_d  = launch ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);

  logic [WIDTH-1:0] mcand_q, mcand_d;
  logic [WIDTH-1:0] acc_hi_q, acc_hi_d;
  logic [WIDTH-1:0] acc_lo_q, acc_lo_d;
  logic [WIDTH:0]   sum;
  logic             en;

  assign sum = {1'b0, acc_hi_q} + {1'b0, (acc_lo_q[0] ? mcand_q : '0)};
  assign en  = load | step;

  always_comb begin
    if (load) begin
      mcand_d  = mcand_i;
      acc_hi_d = '0;
      acc_lo_d = mplier_i;
    end else begin
      mcand_d  = mcand_q;
      acc_hi_d = sum[WIDTH:1];
      acc_lo_d = {sum[0], acc_lo_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      acc_hi_q <= '0;
      acc_lo_q <= '0;
    end else if (en) begin
      mcand_q  <= mcand_d;
      acc_hi_q <= acc_hi_d;
      acc_lo_q <= acc_lo_d;
    end
  end

  assign prod_o = {acc_hi_q, acc_lo_q};

endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] dvnd_i,
  input  logic [WIDTH-1:0] dvsr_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);

  logic [WIDTH-1:0] rem_q, rem_d;
  logic [WIDTH-1:0] quo_q, quo_d;
  logic [WIDTH-1:0] dvsr_q, dvsr_d;
  logic [WIDTH-1:0] shifted_low;
  logic [WIDTH-1:0] diff;
  logic             fits;
  logic             en;

  // The partial remainder shifted left by one with the next dividend bit.
  // Its top bit (rem_q MSB) being set means it already exceeds any divisor.
  assign shifted_low = {rem_q[WIDTH-2:0], quo_q[WIDTH-1]};
  assign fits        = rem_q[WIDTH-1] | (shifted_low >= dvsr_q);
  assign diff        = shifted_low - dvsr_q;
  assign en          = load | step;

  always_comb begin
    if (load) begin
      rem_d  = '0;
      quo_d  = dvnd_i;
      dvsr_d = dvsr_i;
    end else begin
      rem_d  = fits ? diff : shifted_low;
      quo_d  = {quo_q[WIDTH-2:0], fits};
      dvsr_d = dvsr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvsr_q <= '0;
    end else if (en) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvsr_q <= dvsr_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             busy,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);

  localparam int PROD_W = 2 * WIDTH;

  logic              accept, is_arith, is_signed, is_div_req;
  logic              ld_hi, ld_lo;
  logic              a_neg, b_neg, b_zero;
  logic [WIDTH-1:0]  mag_a, mag_b;
  logic              step, fix;
  logic              mul_load, div_load;
  logic [PROD_W-1:0] prod_raw, prod_fix;
  logic [WIDTH-1:0]  quo_raw, rem_raw, quo_fix, rem_fix;

  logic              is_div_q, neg_prod_q, neg_quo_q, neg_rem_q;
  logic              is_div_d, neg_prod_d, neg_quo_d, neg_rem_d;
  logic [WIDTH-1:0]  hi_q, hi_d, lo_q, lo_d;
  logic              hi_en, lo_en;

  // Request decode: only an idle unit accepts anything.
  assign is_arith   = (op == OP_SMUL) || (op == OP_UMUL) ||
                      (op == OP_SDIV) || (op == OP_UDIV);
  assign is_signed  = (op == OP_SMUL) || (op == OP_SDIV);
  assign is_div_req = (op == OP_SDIV) || (op == OP_UDIV);
  assign accept     = start && !busy && is_arith;
  assign ld_hi      = start && !busy && (op == OP_LDHI);
  assign ld_lo      = start && !busy && (op == OP_LDLO);

  // Operand magnitudes for the unsigned iterative cores.
  assign a_neg  = is_signed & opa[WIDTH-1];
  assign b_neg  = is_signed & opb[WIDTH-1];
  assign b_zero = (opb == '0);
  assign mag_a  = a_neg ? (~opa + 1'b1) : opa;
  assign mag_b  = b_neg ? (~opb + 1'b1) : opb;

  assign mul_load = accept & ~is_div_req;
  assign div_load = accept &  is_div_req;

  muldiv_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (accept),
    .busy   (busy),
    .step   (step),
    .fix    (fix)
  );

  muldiv_mul_core #(.WIDTH(WIDTH)) mul_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (mul_load),
    .step     (step & ~is_div_q),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .prod_o   (prod_raw)
  );

  muldiv_div_core #(.WIDTH(WIDTH)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (div_load),
    .step   (step & is_div_q),
    .dvnd_i (mag_a),
    .dvsr_i (mag_b),
    .quo_o  (quo_raw),
    .rem_o  (rem_raw)
  );

  // Sign bookkeeping captured at launch. A zero divisor keeps the
  // all-ones quotient uncorrected; the remainder then rebuilds the dividend.
  always_comb begin
    is_div_d   = is_div_req;
    neg_prod_d = a_neg ^ b_neg;
    neg_quo_d  = (a_neg ^ b_neg) & ~b_zero;
    neg_rem_d  = a_neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_div_q   <= 1'b0;
      neg_prod_q <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
    end else if (accept) begin
      is_div_q   <= is_div_d;
      neg_prod_q <= neg_prod_d;
      neg_quo_q  <= neg_quo_d;
      neg_rem_q  <= neg_rem_d;
    end
  end

  // Sign-correction stage, used in the final cycle of a sequence.
  assign prod_fix = neg_prod_q ? (~prod_raw + 1'b1) : prod_raw;
  assign quo_fix  = neg_quo_q  ? (~quo_raw + 1'b1)  : quo_raw;
  assign rem_fix  = neg_rem_q  ? (~rem_raw + 1'b1)  : rem_raw;

  // Result pair next state.
  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    hi_en = 1'b0;
    lo_en = 1'b0;
    if (fix) begin
      hi_en = 1'b1;
      lo_en = 1'b1;
      if (is_div_q) begin
        hi_d = rem_fix;
        lo_d = quo_fix;
      end else begin
        hi_d = prod_fix[PROD_W-1:WIDTH];
        lo_d = prod_fix[WIDTH-1:0];
      end
    end else begin
      if (ld_hi) begin
        hi_en = 1'b1;
        hi_d  = opa;
      end
      if (ld_lo) begin
        lo_en = 1'b1;
        lo_d  = opa;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             busy,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo
);

  localparam int CW = $clog2(WIDTH) + 2;

  logic             acc;
  logic [CW-1:0]    busy_cnt;
  logic [2:0]       cap_op;
  logic [WIDTH-1:0] cap_a, cap_b;

  assign acc = start && !busy && (op < 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end else begin
      busy_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op <= 3'd7;
      cap_a  <= '0;
      cap_b  <= '0;
    end else if (acc) begin
      cap_op <= op;
      cap_a  <= opa;
      cap_b  <= opb;
    end
  end

  assert_busy_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc));

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CW'(WIDTH + 1)));

  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(hi) && $stable(lo)));

  assert_load_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == OP_LDHI) |=> (hi == $past(opa)) && $stable(lo) && !busy);

  assert_load_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == OP_LDLO) |=> (lo == $past(opa)) && $stable(hi) && !busy);

  assert_noop_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op >= 3'd6) |=> !busy && $stable(hi) && $stable(lo));

  assert_umul_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cap_op == OP_UMUL) |->
      ({hi, lo} == ({{WIDTH{1'b0}}, cap_a} * {{WIDTH{1'b0}}, cap_b})));

  assert_div_by_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && (cap_op == OP_UDIV || cap_op == OP_SDIV) && cap_b == '0) |->
      (lo == '1) && (hi == cap_a));

endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .op    (op),
  .opa   (opa),
  .opb   (opb),
  .busy  (busy),
  .hi    (hi),
  .lo    (lo)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [2:0]   op;
  logic [W-1:0] opa, opb;
  logic         busy;
  logic [W-1:0] hi, lo;

  muldiv_unit #(.WIDTH(W)) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .opa   (opa),
    .opb   (opb),
    .busy  (busy),
    .hi    (hi),
    .lo    (lo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          cmp_on = 0;
  bit          done = 0;
  string       cur_req = "R9";

  // Reference model state
  int          m_cnt;
  logic [31:0] m_hi, m_lo, p_hi, p_lo;

  function automatic void calc(input logic [2:0] o, input logic [31:0] a, b,
                               output logic [31:0] rh, output logic [31:0] rl);
    logic [63:0] p;
    int ia, ib;
    ia = int'(a);
    ib = int'(b);
    rh = '0;
    rl = '0;
    case (o)
      3'd0: begin
        p = 64'(longint'(ia) * longint'(ib));
        rh = p[63:32]; rl = p[31:0];
      end
      3'd1: begin
        p = {32'd0, a} * {32'd0, b};
        rh = p[63:32]; rl = p[31:0];
      end
      3'd2: begin
        if (b == 32'd0) begin rl = 32'hFFFF_FFFF; rh = a; end
        else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin rl = a; rh = 32'd0; end
        else begin rl = 32'(ia / ib); rh = 32'(ia % ib); end
      end
      3'd3: begin
        if (b == 32'd0) begin rl = 32'hFFFF_FFFF; rh = a; end
        else begin rl = a / b; rh = a % b; end
      end
      default: begin rh = '0; rl = '0; end
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hi = '0; m_lo = '0; p_hi = '0; p_lo = '0;
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin m_hi = p_hi; m_lo = p_lo; end
    end else if (start) begin
      if (op < 3'd4) begin
        calc(op, opa, opb, p_hi, p_lo);
        m_cnt = 33;
      end else if (op == 3'd4) m_hi = opa;
      else if (op == 3'd5) m_lo = opa;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R6", "busy", {31'd0, busy}, {31'd0, (m_cnt > 0)});
      chk(cur_req, "hi", hi, m_hi);
      chk(cur_req, "lo", lo, m_lo);
    end
  end

  task automatic issue(input logic [2:0] o, input logic [31:0] a, b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0; op = 3'd7; opa = '0; opb = '0;
  endtask

  task automatic run_op(input string req, input logic [2:0] o, input logic [31:0] a, b);
    logic [31:0] eh, el;
    int hcnt;
    cur_req = req;
    calc(o, a, b, eh, el);
    issue(o, a, b);
    hcnt = busy ? 1 : 0;
    for (int i = 0; i < 33; i++) begin
      @(negedge clk);
      if (busy) hcnt++;
    end
    chk(req, "hi result", hi, eh);
    chk(req, "lo result", lo, el);
    chk("R6", "busy cycles", 32'(hcnt), 32'd33);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] eh, el;
    rst_n = 1'b0; start = 1'b0; op = 3'd7; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    chk("R9", "busy at reset", {31'd0, busy}, 32'd0);
    chk("R9", "hi at reset", hi, 32'd0);
    chk("R9", "lo at reset", lo, 32'd0);
    rst_n = 1'b1;
    cmp_on = 1;

    run_op("R1", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R1", 3'd1, 32'h1234_5678, 32'h9ABC_DEF0);
    run_op("R2", 3'd0, 32'hFFFF_FFFD, 32'd7);
    run_op("R2", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R2", 3'd0, 32'h8000_0000, 32'h8000_0000);
    run_op("R3", 3'd3, 32'd100, 32'd7);
    run_op("R3", 3'd3, 32'hFFFF_FFFF, 32'd16);
    run_op("R4", 3'd2, 32'hFFFF_FFF9, 32'd2);
    run_op("R4", 3'd2, 32'd7, 32'hFFFF_FFFE);
    run_op("R4", 3'd2, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R5", 3'd3, 32'hDEAD_BEEF, 32'd0);
    run_op("R5", 3'd2, 32'hFFFF_FFFB, 32'd0);

    // R7: direct loads take effect at once and leave busy low
    cur_req = "R7";
    issue(3'd4, 32'hA5A5_0001, 32'd0);
    chk("R7", "hi after load", hi, 32'hA5A5_0001);
    chk("R7", "busy after load", {31'd0, busy}, 32'd0);
    issue(3'd5, 32'h0F0F_0002, 32'd0);
    chk("R7", "lo after load", lo, 32'h0F0F_0002);
    chk("R7", "hi kept", hi, 32'hA5A5_0001);

    // R10: codes 6 and 7 do nothing
    cur_req = "R10";
    issue(3'd6, 32'h1111_1111, 32'd3);
    chk("R10", "busy code 6", {31'd0, busy}, 32'd0);
    chk("R10", "hi code 6", hi, 32'hA5A5_0001);
    issue(3'd7, 32'h2222_2222, 32'd5);
    @(negedge clk);
    chk("R10", "busy code 7", {31'd0, busy}, 32'd0);
    chk("R10", "lo code 7", lo, 32'h0F0F_0002);

    // R8: requests during a running multiply are dropped
    cur_req = "R8";
    calc(3'd1, 32'd1000, 32'd3000, eh, el);
    issue(3'd1, 32'd1000, 32'd3000);
    issue(3'd5, 32'hBAD0_BAD0, 32'd0);
    chk("R8", "lo held during busy", lo, 32'h0F0F_0002);
    issue(3'd3, 32'd9, 32'd2);
    issue(3'd4, 32'hBAD1_BAD1, 32'd0);
    chk("R8", "hi held during busy", hi, 32'hA5A5_0001);
    repeat (30) @(negedge clk);
    chk("R8", "hi from first op", hi, eh);
    chk("R8", "lo from first op", lo, el);
    chk("R8", "busy cleared", {31'd0, busy}, 32'd0);

    // Mixed random operations
    for (int i = 0; i < 24; i++) begin
      logic [2:0]  ro;
      logic [31:0] ra, rb;
      ro = 3'($urandom_range(0, 3));
      ra = $urandom();
      rb = (i % 6 == 5) ? 32'd0 : ((i % 3 == 0) ? 32'($urandom_range(1, 300)) : $urandom());
      case (ro)
        3'd0: run_op("R2", ro, ra, rb);
        3'd1: run_op("R1", ro, ra, rb);
        3'd2: run_op("R4", ro, ra, rb);
        default: run_op("R3", ro, ra, rb);
      endcase
    end

    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule